// File: doc/BRIEF.md
# Clause-22 Management Responder

This block sits on the PHY side of a two-wire management link that a host drives by bit-banging. It watches the management clock, the host's data line and the host's output-enable line. It finds frames in the serial stream, decodes read and write requests, and answers reads by driving register contents back on a single data-in line toward the host.

The register space has 32 entries of 16 bits each. Two identifier entries hold fixed nonzero values and all other entries read as zero. Write requests are decoded and run to completion, but their data is thrown away, so the register contents never change. All edge detection takes place in the system clock domain: the management clock is treated as a slow data signal and compared with a registered copy of itself. A separate PHY reset input lets the host abort a transaction in progress.

Top module: `mdio_target`

## Requirements
- R1: The serial bit taken on each rising edge of `mgmt_clk` is 1 only when `host_dout` and `host_oe` are both high, and 0 otherwise. A run of ones with `host_oe` low therefore does not count as a preamble.
- R2: Frame sync is gained when the last 32 sampled bits are all ones. A run of 31 ones followed by a header gives no response. A run longer than 32 ones still syncs.
- R3: The 16 bits that follow sync form the header, sent MSB first: start (2 bits), opcode (2), PHY address (5), register address (5), turnaround (2). A frame is acted on only when start is 01 and opcode is 10 (read) or 01 (write). Any other start or opcode value leaves `host_din` unchanged.
- R4: A read is accepted when the low turnaround bit is 0 (turnaround 00 or 10). A turnaround with its low bit set causes the read to be ignored.
- R5: A write is accepted only with turnaround 10. Its 16 data bits are discarded, and a later read of the same register returns the unchanged value.
- R6: On an accepted read, the addressed register is output on `host_din` MSB first, one bit on each of the 16 rising edges that follow the header.
- R7: After the 16th data edge the transaction ends. Further edges do not change `host_din` until a new frame is accepted.
- R8: Register 2 reads 0x0022, register 3 reads 0x161A, and every other register reads 0x0000. The PHY address field does not affect which value is returned.
- R9: `phy_rst` high clears the transaction state and the bit counter. A read cut short by it drives no further bits, and the next complete frame is served normally.
- R10: `host_din` is a register. It is 0 after `rst_n` and changes only in the system clock cycle in which a rising `mgmt_clk` edge is detected during a read data phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_rst | input | 1 | Host PHY reset; aborts any transaction and clears the counter |
| mgmt_clk | input | 1 | Management clock from the host, sampled by `clk` |
| host_dout | input | 1 | Serial data driven by the host |
| host_oe | input | 1 | Host output enable; when low the host's data is read as 0 |
| host_din | output | 1 | Registered serial data returned to the host |

## Verification
On every cycle the assertions check that the counter stays within its sync range and reloads on a run of ones, that a transaction goes idle when its count runs out, that PHY reset clears state, and that `host_din` only moves on a detected edge and never during a write. Which frames are accepted and which are rejected, the exact bit order of read data, the register values, and the proof that writes leave registers unchanged can only be shown by the bench's end-to-end frames. Those frames include short and masked preambles and a read cut short by reset.

// File: rtl/mdio_target_pkg.sv
package mdio_target_pkg;

    typedef enum logic [1:0] {
        XACT_IDLE  = 2'd0,
        XACT_READ  = 2'd1,
        XACT_WRITE = 2'd2
    } xact_e;

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] TA_WRITE   = 2'b10;

endpackage

// File: rtl/mdio_edge.sv
module mdio_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic mgmt_clk,
    output logic rise
);
    logic mgmt_clk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mgmt_clk_q <= 1'b0;
        else        mgmt_clk_q <= mgmt_clk;
    end

    assign rise = mgmt_clk & ~mgmt_clk_q;

    // one detection per management clock edge
    p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/mdio_regfile.sv
module mdio_regfile #(
    parameter int          DATA_W   = 16,
    parameter int          ADDR_W   = 5,
    parameter int          ID_A_IDX = 2,
    parameter int          ID_B_IDX = 3,
    parameter logic [15:0] ID_A     = 16'h0022,
    parameter logic [15:0] ID_B     = 16'h161A
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int REG_CNT = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [REG_CNT];

    // contents are fixed: writes are discarded upstream (R5, R8)
    for (genvar i = 0; i < REG_CNT; i++) begin : g_reg
        if (i == ID_A_IDX) begin : g_id_a
            assign regs[i] = DATA_W'(ID_A);
        end else if (i == ID_B_IDX) begin : g_id_b
            assign regs[i] = DATA_W'(ID_B);
        end else begin : g_zero
            assign regs[i] = '0;
        end
    end

    assign rd_data = regs[rd_addr];
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_target_pkg::*;
#(
    parameter int HIST_W = 32,
    parameter int HDR_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phy_rst,
    input  logic              rise,
    input  logic              host_dout,
    input  logic              host_oe,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              host_din
);
    localparam int               CNT_W    = $clog2(HIST_W + 1);
    localparam logic [CNT_W-1:0] CNT_SYNC = CNT_W'(HIST_W);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
        logic [CNT_W-1:0]  cnt;
        xact_e             state;
        logic [DATA_W-1:0] dout;
        logic              din;
    } frame_t;

    frame_t st_d, st_q;

    logic              bit_s;
    logic [HIST_W-1:0] hist_nx;
    logic              sync_s;

    assign bit_s   = host_dout & host_oe;                  // R1
    assign hist_nx = {st_q.hist[HIST_W-2:0], bit_s};
    assign sync_s  = (hist_nx == '1);                      // R2
    assign rd_addr = hist_nx[ADDR_W+1:2];

    always_comb begin
        logic [CNT_W-1:0] c;
        logic [1:0]       f_start, f_op, f_ta;
        st_d    = st_q;
        c       = st_q.cnt;
        f_start = hist_nx[HDR_W-1:HDR_W-2];
        f_op    = hist_nx[HDR_W-3:HDR_W-4];
        f_ta    = hist_nx[1:0];
        if (rise) begin
            st_d.hist = hist_nx;
            if (sync_s) c = CNT_SYNC;
            if (c == CNT_HDR) begin                        // R3
                if (f_start == START_CODE && f_op == OP_WRITE && f_ta == TA_WRITE) begin
                    st_d.state = XACT_WRITE;               // R5
                end else if (f_start == START_CODE && f_op == OP_READ && !f_ta[0]) begin
                    st_d.state = XACT_READ;                // R4
                    st_d.dout  = rd_data;
                end else begin
                    st_d.state = XACT_IDLE;
                end
            end
            if (c < CNT_HDR && st_d.state == XACT_READ) begin  // R6
                st_d.din  = st_d.dout[DATA_W-1];
                st_d.dout = {st_d.dout[DATA_W-2:0], 1'b0};
            end
            if (c == '0) st_d.state = XACT_IDLE;           // R7, write data dropped
            st_d.cnt = (c == '0) ? '0 : c - 1'b1;
        end
        if (phy_rst) begin                                 // R9
            st_d.state = XACT_IDLE;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= XACT_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_din = st_q.din;

    p_cnt_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_SYNC);

    p_sync_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && sync_s && !phy_rst) |=> st_q.cnt == CNT_SYNC - 1'b1);

    p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && st_q.cnt == '0 && !sync_s) |=> st_q.state == XACT_IDLE);

    p_phy_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst |=> (st_q.state == XACT_IDLE && st_q.cnt == '0));

    p_din_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable(host_din));

    p_write_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.state == XACT_WRITE |=> $stable(host_din));
endmodule

// File: rtl/mdio_target.sv
module mdio_target #(
    parameter int          HIST_W = 32,
    parameter int          HDR_W  = 16,
    parameter int          DATA_W = 16,
    parameter int          ADDR_W = 5,
    parameter logic [15:0] ID_A   = 16'h0022,
    parameter logic [15:0] ID_B   = 16'h161A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phy_rst,
    input  logic mgmt_clk,
    input  logic host_dout,
    input  logic host_oe,
    output logic host_din
);
    logic              rise;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    mdio_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .mgmt_clk (mgmt_clk),
        .rise     (rise)
    );

    mdio_regfile #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .ID_A_IDX (2),
        .ID_B_IDX (3),
        .ID_A     (ID_A),
        .ID_B     (ID_B)
    ) u_regs (
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    mdio_frame #(
        .HIST_W (HIST_W),
        .HDR_W  (HDR_W),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_rst   (phy_rst),
        .rise      (rise),
        .host_dout (host_dout),
        .host_oe   (host_oe),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .host_din  (host_din)
    );
endmodule

// File: tb/tb_mdio_target.sv
module tb_mdio_target;
    localparam int CLK_PERIOD = 10;
    localparam int NV         = 14;

    logic clk = 1'b0;
    logic rst_n, phy_rst, mgmt_clk, host_dout, host_oe;
    logic host_din;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic last_din;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_target dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .phy_rst   (phy_rst),
        .mgmt_clk  (mgmt_clk),
        .host_dout (host_dout),
        .host_oe   (host_oe),
        .host_din  (host_din)
    );

    typedef struct packed {
        logic [5:0]  pre;
        logic [1:0]  start;
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [1:0]  ta;
        logic [15:0] wdat;
        logic        resp;
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{6'd32, 2'b01, 2'b10, 5'd0,  5'd2,  2'b00, 16'h0000, 1'b1, 16'h0022}, // R6 R8
        '{6'd40, 2'b01, 2'b10, 5'd7,  5'd3,  2'b10, 16'h0000, 1'b1, 16'h161A}, // R2 R4
        '{6'd32, 2'b01, 2'b10, 5'd0,  5'd3,  2'b01, 16'h0000, 1'b0, 16'h0000}, // R4
        '{6'd32, 2'b01, 2'b10, 5'd0,  5'd2,  2'b11, 16'h0000, 1'b0, 16'h0000}, // R4
        '{6'd32, 2'b01, 2'b01, 5'd0,  5'd3,  2'b10, 16'hFFFF, 1'b0, 16'h0000}, // R5
        '{6'd32, 2'b01, 2'b10, 5'd31, 5'd3,  2'b00, 16'h0000, 1'b1, 16'h161A}, // R5 R8
        '{6'd32, 2'b00, 2'b10, 5'd0,  5'd3,  2'b00, 16'h0000, 1'b0, 16'h0000}, // R3
        '{6'd32, 2'b01, 2'b00, 5'd0,  5'd3,  2'b00, 16'h0000, 1'b0, 16'h0000}, // R3
        '{6'd32, 2'b01, 2'b11, 5'd0,  5'd3,  2'b00, 16'h0000, 1'b0, 16'h0000}, // R3
        '{6'd32, 2'b01, 2'b10, 5'd0,  5'd0,  2'b00, 16'h0000, 1'b1, 16'h0000}, // R8
        '{6'd32, 2'b01, 2'b10, 5'd9,  5'd31, 2'b00, 16'h0000, 1'b1, 16'h0000}, // R8
        '{6'd32, 2'b01, 2'b01, 5'd0,  5'd2,  2'b00, 16'h1234, 1'b0, 16'h0000}, // R5
        '{6'd31, 2'b01, 2'b10, 5'd0,  5'd3,  2'b00, 16'h0000, 1'b0, 16'h0000}, // R2
        '{6'd32, 2'b01, 2'b10, 5'd0,  5'd2,  2'b00, 16'h0000, 1'b1, 16'h0022}  // R6
    };

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic mbit(input logic o, input logic e);
        @(negedge clk); mgmt_clk = 1'b0; host_dout = o; host_oe = e;
        @(negedge clk);
        @(negedge clk); mgmt_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send_head(input int pre, input logic pre_oe, input logic [1:0] st,
                             input logic [1:0] op, input logic [4:0] phy,
                             input logic [4:0] rg, input logic [1:0] ta);
        logic [15:0] h;
        h = {st, op, phy, rg, ta};
        for (int i = 0; i < pre; i++) mbit(1'b1, pre_oe);
        for (int i = 15; i >= 0; i--) mbit(h[i], 1'b1);
    endtask

    task automatic data_phase(input int nbits, input logic [15:0] w, input logic drv,
                              output logic [15:0] got);
        got = '0;
        for (int i = 15; i > 15 - nbits; i--) begin
            mbit(w[i], drv);
            got[i] = host_din;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] got;
        rst_n = 1'b0; phy_rst = 1'b0; mgmt_clk = 1'b0; host_dout = 1'b0; host_oe = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset value", {15'd0, host_din}, 16'h0000);
        last_din = 1'b0;

        // table of frames
        for (int v = 0; v < NV; v++) begin
            send_head(int'(VECS[v].pre), 1'b1, VECS[v].start, VECS[v].op,
                      VECS[v].phy, VECS[v].rg, VECS[v].ta);
            data_phase(16, VECS[v].wdat, VECS[v].op == 2'b01, got);
            if (VECS[v].resp) begin
                chk($sformatf("R6 vector %0d", v), got, VECS[v].exp);
                last_din = VECS[v].exp[0];
            end else begin
                chk($sformatf("R3/R4/R5 ignored vector %0d", v), got, {16{last_din}});
            end
        end

        // R1: ones with output enable low are not a preamble
        send_head(32, 1'b0, 2'b01, 2'b10, 5'd0, 5'd3, 2'b00);
        data_phase(16, 16'h0000, 1'b0, got);
        chk("R1 masked preamble", got, {16{last_din}});

        // R9/R10: partial read, hold between edges, then PHY reset abort
        send_head(32, 1'b1, 2'b01, 2'b10, 5'd0, 5'd3, 2'b00);
        data_phase(4, 16'h0000, 1'b0, got);
        chk("R6 partial read bits", got, 16'h1000);
        repeat (20) @(negedge clk);
        chk("R10 hold between edges", {15'd0, host_din}, 16'h0001);
        @(negedge clk); phy_rst = 1'b1;
        @(negedge clk); phy_rst = 1'b0;
        data_phase(16, 16'h0000, 1'b0, got);
        chk("R9 aborted read drives nothing", got, 16'hFFFF);
        send_head(32, 1'b1, 2'b01, 2'b10, 5'd4, 5'd2, 2'b00);
        data_phase(16, 16'h0000, 1'b0, got);
        chk("R9 read after abort", got, 16'h0022);

        // R7: edges after the transaction do not move host_din
        data_phase(16, 16'hA5A5, 1'b1, got);
        chk("R7 idle after data phase", got, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule